// File: doc/BRIEF.md
# Disk Task-File Register Controller

This block is the device side of a parallel disk interface. A host reaches it through a byte-wide window of eight registers, with offset 0 widened to a 16-bit data port. The window holds a sector count, a 24-bit block address and a device/mode byte. A write to offset 7 launches a command. The block sequences the busy, ready, data-request and error status bits for each command and drives a level interrupt that the host clears by reading status.

Four commands are supported. Identify presents 256 data words generated inside the block. DMA read and DMA write hand the latched address and count to an external bus-master engine and wait for its completion pulse. Flush cache hands off to a flush backend. Any other code, including the packet code, is rejected with an error. The storage medium and the bus-master engine sit outside the block.

Top module: `ata_tf_ctrl`

## Requirements
- R1: After reset the status byte (offset 7) reads 0x40 (ready only), the interrupt is low, and neither the DMA request nor the flush request is asserted.
- R2: Offsets 1 (feature), 2 (sector count), 3, 4 and 5 (address bits 7:0, 15:8 and 23:16) and 6 (device) read back the last byte written. The address drives dma_lba_o and the count drives dma_count_o.
- R3: Command 0xEC (identify) gives status 0x48 (ready 0x40 plus data request 0x08) and raises the interrupt. The next 256 reads of offset 0 return the identify words: word 0 = 0x0040, word 60 = capacity bits 15:0, word 61 = capacity bits 31:16, word 85 = 0x0020 (bit 5 means the write cache is enabled), and every other word 0. Data request stays set, with busy clear, until the last word has been read.
- R4: After the 256th word, status returns to 0x40 and further data reads return 0.
- R5: Command 0xC8 (DMA read) or 0xCA (DMA write) gives status 0xC0 (busy 0x80 plus ready) and asserts dma_req_o. dma_dir_o is 1 for 0xC8 (device to memory) and 0 for 0xCA. A dma_done_i pulse drops the request, sets status to 0x40, or to 0x41 if dma_err_i is high, and raises the interrupt.
- R6: Command 0xE7 (flush) gives status 0xC0 and asserts flush_req_o until a flush_done_i pulse. The pulse sets status to 0x40 and raises the interrupt.
- R7: A read of offset 7 clears the interrupt, unless a completion event raises it in the same cycle.
- R8: A command write while busy is set is ignored: status, requests and direction are unchanged.
- R9: Any other command code, including 0xA0 (packet), sets status to 0x41 (ready plus error 0x01) and raises the interrupt.
- R10: Busy and data request are never set together, and ready is always set.
- R11: An accepted command clears an error bit left by the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access; side effects at the clock edge |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Level interrupt |
| dma_req_o | output | 1 | DMA transfer requested |
| dma_dir_o | output | 1 | 1 = device to memory, 0 = memory to device |
| dma_lba_o | output | 24 | Latched block address |
| dma_count_o | output | 8 | Latched sector count |
| dma_done_i | input | 1 | DMA completion pulse |
| dma_err_i | input | 1 | Error flag, qualified by dma_done_i |
| flush_req_o | output | 1 | Flush requested |
| flush_done_i | input | 1 | Flush completion pulse |

## Verification
The assertions take for granted that dma_done_i pulses only while dma_req_o is high and flush_done_i only while flush_req_o is high, and that read and write strobes never share a cycle. The bench keeps to this: it pulses each completion input for one cycle, only after it has seen the matching request. Every bus access is a single-strobe cycle driven on the falling edge.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int unsigned ID_WORDS = 256;

  localparam logic [7:0] ST_BSY = 8'h80;
  localparam logic [7:0] ST_RDY = 8'h40;
  localparam logic [7:0] ST_DRQ = 8'h08;
  localparam logic [7:0] ST_ERR = 8'h01;

  localparam logic [7:0] CMD_RD_DMA = 8'hC8;
  localparam logic [7:0] CMD_WR_DMA = 8'hCA;
  localparam logic [7:0] CMD_FLUSH  = 8'hE7;
  localparam logic [7:0] CMD_IDENT  = 8'hEC;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_FEAT = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_A0   = 3'd3;
  localparam logic [2:0] OFS_DEV  = 3'd6;
  localparam logic [2:0] OFS_CMD  = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_PIO, S_DMA, S_FLUSH} seq_state_e;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int unsigned LBA_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       count_o,
  output logic [LBA_W-1:0] lba_o,
  output logic [7:0]       rdata_o
);
  localparam int unsigned NB = LBA_W / 8;

  logic [7:0] feat_q, cnt_q, dev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      feat_q <= '0;
      cnt_q  <= '0;
      dev_q  <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_FEAT) feat_q <= wdata_i;
      if (addr_i == OFS_CNT)  cnt_q  <= wdata_i;
      if (addr_i == OFS_DEV)  dev_q  <= wdata_i;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lba
    localparam logic [2:0] OFS = 3'(int'(OFS_A0) + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lba_o[g*8 +: 8] <= '0;
      else if (we_i && addr_i == OFS) lba_o[g*8 +: 8] <= wdata_i;
    end
  end

  assign count_o = cnt_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_FEAT) rdata_o = feat_q;
    if (addr_i == OFS_CNT)  rdata_o = cnt_q;
    if (addr_i == OFS_DEV)  rdata_o = dev_q;
    for (int i = 0; i < int'(NB); i++) begin
      if (addr_i == 3'(int'(OFS_A0) + i)) rdata_o = lba_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
  parameter int unsigned ID_WORDS = 256,
  parameter logic [31:0] CAPACITY = 32'h0012_3400
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        adv_i,
  output logic [15:0] word_o,
  output logic        last_o
);
  localparam int unsigned IDX_W = $clog2(ID_WORDS);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (adv_i)   idx_q <= idx_q + 1'b1;
  end

  assign last_o = (idx_q == IDX_W'(ID_WORDS - 1));

  always_comb begin
    word_o = '0;
    if (idx_q == IDX_W'(0))  word_o = 16'h0040;
    if (idx_q == IDX_W'(60)) word_o = CAPACITY[15:0];
    if (idx_q == IDX_W'(61)) word_o = CAPACITY[31:16];
    if (idx_q == IDX_W'(85)) word_o = 16'h0020;  // write cache enabled
  end
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_we_i,
  input  logic [7:0] cmd_i,
  input  logic       data_rd_i,
  input  logic       stat_rd_i,
  input  logic       id_last_i,
  input  logic       dma_done_i,
  input  logic       dma_err_i,
  input  logic       flush_done_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       dma_req_o,
  output logic       dma_dir_o,
  output logic       flush_req_o,
  output logic       id_start_o,
  output logic       id_adv_o
);
  seq_state_e state_q;
  logic err_q, irq_q, dir_q;
  logic bsy, drq, accept;

  assign bsy    = (state_q == S_DMA) || (state_q == S_FLUSH);
  assign drq    = (state_q == S_PIO);
  assign accept = cmd_we_i && !bsy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      if (stat_rd_i) irq_q <= 1'b0;
      unique case (state_q)
        S_IDLE, S_PIO: begin
          if (drq && data_rd_i && id_last_i) state_q <= S_IDLE;
          if (accept) begin
            err_q   <= 1'b0;
            state_q <= S_IDLE;
            unique case (cmd_i)
              CMD_IDENT: begin
                state_q <= S_PIO;
                irq_q   <= 1'b1;
              end
              CMD_RD_DMA: begin
                state_q <= S_DMA;
                dir_q   <= 1'b1;
              end
              CMD_WR_DMA: begin
                state_q <= S_DMA;
                dir_q   <= 1'b0;
              end
              CMD_FLUSH: state_q <= S_FLUSH;
              default: begin
                err_q <= 1'b1;
                irq_q <= 1'b1;
              end
            endcase
          end
        end
        S_DMA: if (dma_done_i) begin
          state_q <= S_IDLE;
          err_q   <= dma_err_i;
          irq_q   <= 1'b1;
        end
        S_FLUSH: if (flush_done_i) begin
          state_q <= S_IDLE;
          irq_q   <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign status_o    = ST_RDY | (bsy ? ST_BSY : 8'h00) | (drq ? ST_DRQ : 8'h00)
                     | (err_q ? ST_ERR : 8'h00);
  assign irq_o       = irq_q;
  assign dma_req_o   = (state_q == S_DMA);
  assign dma_dir_o   = dir_q;
  assign flush_req_o = (state_q == S_FLUSH);
  assign id_start_o  = accept && (cmd_i == CMD_IDENT);
  assign id_adv_o    = drq && data_rd_i;
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
#(
  parameter int unsigned LBA_W    = 24,
  parameter logic [31:0] CAPACITY = 32'h0012_3400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [7:0]       bus_wdata_i,
  output logic [15:0]      bus_rdata_o,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic             dma_dir_o,
  output logic [LBA_W-1:0] dma_lba_o,
  output logic [7:0]       dma_count_o,
  input  logic             dma_done_i,
  input  logic             dma_err_i,
  output logic             flush_req_o,
  input  logic             flush_done_i
);
  logic [7:0]  reg_rdata, status;
  logic [15:0] id_word;
  logic        id_last, id_start, id_adv;
  logic        cmd_we, stat_rd, data_rd;

  assign cmd_we  = bus_wr_i && (bus_addr_i == OFS_CMD);
  assign stat_rd = bus_rd_i && (bus_addr_i == OFS_CMD);
  assign data_rd = bus_rd_i && (bus_addr_i == OFS_DATA);

  ata_tf_regs #(.LBA_W(LBA_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .count_o (dma_count_o),
    .lba_o   (dma_lba_o),
    .rdata_o (reg_rdata)
  );

  ata_tf_ident #(.ID_WORDS(ID_WORDS), .CAPACITY(CAPACITY)) i_ident (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (id_start),
    .adv_i   (id_adv),
    .word_o  (id_word),
    .last_o  (id_last)
  );

  ata_tf_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_we_i     (cmd_we),
    .cmd_i        (bus_wdata_i),
    .data_rd_i    (data_rd),
    .stat_rd_i    (stat_rd),
    .id_last_i    (id_last),
    .dma_done_i   (dma_done_i),
    .dma_err_i    (dma_err_i),
    .flush_done_i (flush_done_i),
    .status_o     (status),
    .irq_o        (irq_o),
    .dma_req_o    (dma_req_o),
    .dma_dir_o    (dma_dir_o),
    .flush_req_o  (flush_req_o),
    .id_start_o   (id_start),
    .id_adv_o     (id_adv)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_DATA: bus_rdata_o = (status & ST_DRQ) != 8'h00 ? id_word : 16'h0000;
      OFS_CMD:  bus_rdata_o = {8'h00, status};
      default:  bus_rdata_o = {8'h00, reg_rdata};
    endcase
  end
endmodule

// File: rtl/ata_tf_checker.sv
module ata_tf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] bus_addr_i,
  input logic       bus_wr_i,
  input logic       bus_rd_i,
  input logic [7:0] status,
  input logic       irq_o,
  input logic       dma_req_o,
  input logic       flush_req_o,
  input logic       dma_done_i,
  input logic       flush_done_i
);
  p_bsy_drq_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status[7] && status[3]));

  p_ready_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[6]);

  p_irq_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == 3'd7 && !bus_wr_i && !dma_done_i && !flush_done_i)
    |=> !irq_o);

  p_busy_cmd_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[7] && bus_wr_i && bus_addr_i == 3'd7 && !dma_done_i && !flush_done_i)
    |=> ($stable(status) && $stable(dma_req_o) && $stable(flush_req_o)));

  p_dma_req_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (status[7] && !flush_req_o));

  p_dma_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && dma_done_i) |=> (!status[7] && irq_o && !dma_req_o));

  p_flush_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && flush_done_i) |=> (status == 8'h40 && irq_o && !flush_req_o));
endmodule

bind ata_tf_ctrl ata_tf_checker i_ata_tf_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .status       (status),
  .irq_o        (irq_o),
  .dma_req_o    (dma_req_o),
  .flush_req_o  (flush_req_o),
  .dma_done_i   (dma_done_i),
  .flush_done_i (flush_done_i)
);

// File: tb/test_ata_tf_ctrl.sv
`timescale 1ns/1ps
module test_ata_tf_ctrl;
  localparam logic [31:0] CAP = 32'h0012_3400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, dma_req, dma_dir, flush_req;
  logic [23:0] dma_lba;
  logic [7:0]  dma_count;
  logic        dma_done = 1'b0, dma_err = 1'b0, flush_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ata_tf_ctrl #(.LBA_W(24), .CAPACITY(CAP)) i_ata_tf_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .irq_o(irq), .dma_req_o(dma_req), .dma_dir_o(dma_dir),
    .dma_lba_o(dma_lba), .dma_count_o(dma_count),
    .dma_done_i(dma_done), .dma_err_i(dma_err),
    .flush_req_o(flush_req), .flush_done_i(flush_done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_dma(input logic e);
    @(negedge clk);
    dma_done = 1'b1; dma_err = e;
    @(negedge clk);
    dma_done = 1'b0; dma_err = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
  endtask

  function automatic logic [15:0] id_exp(input int i);
    if (i == 0)  return 16'h0040;
    if (i == 60) return CAP[15:0];
    if (i == 61) return CAP[31:16];
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 dma_req", 32'(dma_req), 32'd0);
    chk("R1 flush_req", 32'(flush_req), 32'd0);
    rd(3'd7, d);
    chk("R1 status", 32'(d), 32'h40);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(3'd1, 8'h5A); wr(3'd2, 8'h07); wr(3'd3, 8'h11);
    wr(3'd4, 8'h22); wr(3'd5, 8'h33); wr(3'd6, 8'h50);
    rd(3'd1, d); chk("R2 feature", 32'(d), 32'h5A);
    rd(3'd2, d); chk("R2 count", 32'(d), 32'h07);
    rd(3'd3, d); chk("R2 addr lo", 32'(d), 32'h11);
    rd(3'd4, d); chk("R2 addr mid", 32'(d), 32'h22);
    rd(3'd5, d); chk("R2 addr hi", 32'(d), 32'h33);
    rd(3'd6, d); chk("R2 device", 32'(d), 32'h50);
    chk("R2 dma_lba", 32'(dma_lba), 32'h332211);
    chk("R2 dma_count", 32'(dma_count), 32'h07);
  endtask

  task automatic t_identify();
    logic [15:0] d;
    wr(3'd6, 8'h40);
    wr(3'd7, 8'hEC);
    chk("R3 irq raised", 32'(irq), 32'd1);
    rd(3'd7, d);
    chk("R3 status drq", 32'(d), 32'h48);
    chk("R7 irq cleared", 32'(irq), 32'd0);
    for (int i = 0; i < 256; i++) begin
      if (i == 128 || i == 255) begin
        rd(3'd7, d);
        chk("R3 status mid", 32'(d), 32'h48);
      end
      rd(3'd0, d);
      chk($sformatf("R3 word %0d", i), 32'(d), 32'(id_exp(i)));
    end
    rd(3'd7, d);
    chk("R4 status after last", 32'(d), 32'h40);
    rd(3'd0, d);
    chk("R4 data after last", 32'(d), 32'h0);
  endtask

  task automatic t_dma();
    logic [15:0] d;
    wr(3'd7, 8'hC8);
    chk("R5 dma_req rd", 32'(dma_req), 32'd1);
    chk("R5 dir rd", 32'(dma_dir), 32'd1);
    rd(3'd7, d);
    chk("R5 busy", 32'(d), 32'hC0);
    wr(3'd7, 8'hE7);
    chk("R8 flush ignored", 32'(flush_req), 32'd0);
    chk("R8 dma_req kept", 32'(dma_req), 32'd1);
    rd(3'd7, d);
    chk("R8 status kept", 32'(d), 32'hC0);
    wr(3'd7, 8'h00);
    rd(3'd7, d);
    chk("R8 bad code ignored", 32'(d), 32'hC0);
    pulse_dma(1'b0);
    chk("R5 irq done", 32'(irq), 32'd1);
    chk("R5 dma_req dropped", 32'(dma_req), 32'd0);
    rd(3'd7, d);
    chk("R5 status done", 32'(d), 32'h40);
    chk("R7 irq cleared dma", 32'(irq), 32'd0);
    wr(3'd7, 8'hCA);
    chk("R5 dir wr", 32'(dma_dir), 32'd0);
    chk("R5 dma_req wr", 32'(dma_req), 32'd1);
    pulse_dma(1'b1);
    rd(3'd7, d);
    chk("R5 status err", 32'(d), 32'h41);
    wr(3'd7, 8'hC8);
    rd(3'd7, d);
    chk("R11 err cleared", 32'(d), 32'hC0);
    pulse_dma(1'b0);
    rd(3'd7, d);
    chk("R5 status ok", 32'(d), 32'h40);
  endtask

  task automatic t_unknown_flush();
    logic [15:0] d;
    wr(3'd7, 8'hA0);
    chk("R9 irq", 32'(irq), 32'd1);
    chk("R9 no dma", 32'(dma_req), 32'd0);
    rd(3'd7, d);
    chk("R9 status", 32'(d), 32'h41);
    wr(3'd7, 8'h3C);
    rd(3'd7, d);
    chk("R9 status other code", 32'(d), 32'h41);
    wr(3'd7, 8'hE7);
    chk("R6 flush_req", 32'(flush_req), 32'd1);
    rd(3'd7, d);
    chk("R11 R6 busy no err", 32'(d), 32'hC0);
    repeat (5) @(negedge clk);
    chk("R6 still pending", 32'(flush_req), 32'd1);
    pulse_flush();
    chk("R6 irq", 32'(irq), 32'd1);
    chk("R6 flush_req dropped", 32'(flush_req), 32'd0);
    rd(3'd7, d);
    chk("R6 status done", 32'(d), 32'h40);
    chk("R7 irq cleared flush", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_identify();
    t_dma();
    t_unknown_flush();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule